// File: doc/BRIEF.md
# Dual-Bank Measurement Readout Sequencer

This block drains a frame of latched measurement words from a channel array through two output ports at once. The channels are split into two equal banks. Each bank has its own two-stage decoder. The first stage picks one row group and the second stage picks one column inside it. Both decoders are driven from one shared beat address, so they advance together. Every accepted beat therefore delivers one word from each bank, on that bank's own port.

A frame is read as follows. The latch array is loaded first. A single-cycle start pulse then begins the readout. The sequencer presents beat 0, then steps through the addresses each time the downstream side accepts a beat, and flags the final beat. After the final beat is accepted it returns to idle. While the downstream side holds ready low, the address and both words are frozen.

Top module: `dual_bank_readout`

## Requirements
- R1: While reset is asserted (synchronous, active low) and on the first cycle after it is released, `out_valid` and `out_last` are 0, `beat_addr` is 0, and both data ports are 0.
- R2: A `start` pulse sampled while idle makes `out_valid` 1 with `beat_addr` 0 on the next cycle.
- R3: A beat is accepted on a clock edge where both `out_valid` and `in_ready` are 1. Each accepted beat, other than the final one, raises `beat_addr` by exactly one on the next cycle.
- R4: While `out_valid` is 1 and `in_ready` is 0, the next cycle keeps `out_valid`, `beat_addr`, `bank_a_word` and `bank_b_word` unchanged.
- R5: For beat address n, `bank_a_word` is channel n and `bank_b_word` is channel 128+n. Channel k occupies bits [12k+11:12k] of `latch_words`.
- R6: The decoding has two stages. Address bits [6:4] choose one of 8 row groups, and bits [3:0] choose one of 16 columns within that group. During a beat, exactly one row and exactly one column are selected in each bank.
- R7: `out_last` is 1 exactly when `out_valid` is 1 and `beat_addr` is 127. Once that beat is accepted, the next cycle shows `out_valid` 0 and `beat_addr` 0.
- R8: A `start` pulse that arrives while a readout is active has no effect: the beat sequence, the address and the data carry on unchanged.
- R9: While idle, both data ports read 0 and `out_last` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a frame readout |
| in_ready | input | 1 | Downstream can accept the current beat |
| latch_words | input | 3072 | Latched words of all 256 channels, 12 bits each |
| out_valid | output | 1 | A beat is presented |
| out_last | output | 1 | The presented beat is the final one of the frame |
| beat_addr | output | 7 | Current beat address, shared by both banks |
| bank_a_word | output | 12 | Word from the lower bank |
| bank_b_word | output | 12 | Word from the upper bank |

## Verification
The bench builds the block with its default parameters: 8 row groups, 16 columns and 12-bit words. With these values every row and column decode line is exercised, and the step from address 127 back to idle is reached within a few hundred cycles. The frames run with ready held high, with ready dropped at pseudo-random points, and with start pulses injected in the middle of a readout. Each frame loads a different channel pattern, so a wrong row, column or bank selection shows up as a data mismatch.

// File: rtl/rdseq_pkg.sv
// Package: shared constants of the dual-bank readout sequencer.
// Assumes exactly two banks, one per output port.
package rdseq_pkg;
    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/rdseq_addr_ctrl.sv
// Beat address controller: an idle/active flag and one shared beat address.
// Assumes start is a single-cycle pulse issued after the latches are loaded.
module rdseq_addr_ctrl #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_ready,
    output logic              active,
    output logic              at_last,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    // Final-beat flag
    assign at_last = active && (addr == LAST_ADDR);

    // Advance on accepted beats; start is honoured only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            addr   <= '0;
        end else if (active) begin
            if (in_ready) begin
                if (addr == LAST_ADDR) begin
                    active <= 1'b0;
                    addr   <= '0;
                end else begin
                    addr <= addr + 1'b1;
                end
            end
        end else if (start) begin
            active <= 1'b1;
            addr   <= '0;
        end
    end

    AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start) |=> (active && addr == '0)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && in_ready && !at_last) |=> (active && addr == $past(addr) + 1'b1)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !in_ready) |=> (active && $stable(addr))); // R4
    AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && in_ready) |=> (!active && addr == '0)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start && !in_ready) |=> (active && $stable(addr))); // R8
endmodule

// File: rtl/rdseq_decoder.sv
// Two-stage decoder: the upper address bits pick a row group and the lower bits
// pick a column within it. Both outputs are all-zero when disabled.
// Assumes ROWS and COLS are powers of two.
module rdseq_decoder #(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   en,
    input  logic [$clog2(ROWS)+$clog2(COLS)-1:0]   addr,
    output logic [ROWS-1:0]                        row_sel,
    output logic [COLS-1:0]                        col_sel
);
    localparam int unsigned ROW_W = $clog2(ROWS);
    localparam int unsigned COL_W = $clog2(COLS);

    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] col_idx;
    assign row_idx = addr[ROW_W+COL_W-1:COL_W];
    assign col_idx = addr[COL_W-1:0];

    // Stage 1 and stage 2 one-hot selects
    always_comb begin
        row_sel = '0;
        col_sel = '0;
        if (en) begin
            row_sel[row_idx] = 1'b1;
            col_sel[col_idx] = 1'b1;
        end
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(row_sel) == 1)); // R6
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(col_sel) == 1)); // R6
    AST_IDLE_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (row_sel == '0 && col_sel == '0)); // R9
endmodule

// File: rtl/rdseq_bank_mux.sv
// Bank word selector: returns the word where the selected row meets the
// selected column, and zero when nothing is selected.
// Assumes the channel index within a bank is row*COLS + col.
module rdseq_bank_mux #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned COLS   = 16,
    parameter int unsigned WORD_W = 12
) (
    input  logic [ROWS*COLS*WORD_W-1:0] words,
    input  logic [ROWS-1:0]             row_sel,
    input  logic [COLS-1:0]             col_sel,
    output logic [WORD_W-1:0]           word
);
    // AND-OR selection over the row/column grid
    always_comb begin
        word = '0;
        for (int r = 0; r < int'(ROWS); r++) begin
            for (int c = 0; c < int'(COLS); c++) begin
                if (row_sel[r] && col_sel[c])
                    word = word | words[(r*COLS + c)*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/dual_bank_readout.sv
// Dual-bank readout sequencer: one beat address drives two identical two-stage
// decoders in lockstep, and each beat presents one word per bank.
// Assumes latch_words stays stable for the whole readout of a frame.
module dual_bank_readout #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned COLS   = 16,
    parameter int unsigned WORD_W = 12,
    localparam int unsigned BANK_CH = ROWS * COLS,
    localparam int unsigned ADDR_W  = $clog2(BANK_CH),
    localparam int unsigned ALL_CH  = rdseq_pkg::NUM_BANKS * BANK_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_ready,
    input  logic [ALL_CH*WORD_W-1:0] latch_words,
    output logic                     out_valid,
    output logic                     out_last,
    output logic [ADDR_W-1:0]        beat_addr,
    output logic [WORD_W-1:0]        bank_a_word,
    output logic [WORD_W-1:0]        bank_b_word
);
    logic              active;
    logic              at_last;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] bank_word [rdseq_pkg::NUM_BANKS];

    rdseq_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_ready (in_ready),
        .active   (active),
        .at_last  (at_last),
        .addr     (addr)
    );

    // One decoder and selector per bank, all fed by the shared address
    for (genvar b = 0; b < int'(rdseq_pkg::NUM_BANKS); b++) begin : g_bank
        logic [ROWS-1:0] row_sel;
        logic [COLS-1:0] col_sel;

        rdseq_decoder #(.ROWS(ROWS), .COLS(COLS)) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (active),
            .addr    (addr),
            .row_sel (row_sel),
            .col_sel (col_sel)
        );

        rdseq_bank_mux #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_mux (
            .words   (latch_words[b*BANK_CH*WORD_W +: BANK_CH*WORD_W]),
            .row_sel (row_sel),
            .col_sel (col_sel),
            .word    (bank_word[b])
        );
    end

    assign out_valid   = active;
    assign out_last    = at_last;
    assign beat_addr   = addr;
    assign bank_a_word = bank_word[0];
    assign bank_b_word = bank_word[1];

    AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && beat_addr == {ADDR_W{1'b1}})); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (bank_a_word == '0 && bank_b_word == '0 && !out_last)); // R9
    AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_ready && $stable(latch_words)) |=>
        (!$changed(latch_words) -> ($stable(bank_a_word) && $stable(bank_b_word)))); // R4
endmodule

// File: tb/dual_bank_readout_test.sv
module dual_bank_readout_test;
    localparam int W  = 12;
    localparam int CH = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            in_ready = 1'b0;
    logic [CH*W-1:0] latch_words = '0;
    logic            out_valid, out_last;
    logic [6:0]      beat_addr;
    logic [W-1:0]    bank_a_word, bank_b_word;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    int stall_pct = 0;
    bit checking = 1'b0;

    // Behavioural reference state
    bit ref_active = 1'b0;
    int ref_addr = 0;
    logic [W-1:0] prev_a = '0, prev_b = '0;
    bit prev_stall = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dual_bank_readout uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
        .latch_words(latch_words), .out_valid(out_valid), .out_last(out_last),
        .beat_addr(beat_addr), .bank_a_word(bank_a_word), .bank_b_word(bank_b_word)
    );

    function automatic logic [W-1:0] chan(int k);
        return latch_words[k*W +: W];
    endfunction

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_active = 1'b0;
            ref_addr = 0;
        end else if (ref_active) begin
            if (in_ready) begin
                if (ref_addr == 127) begin
                    ref_active = 1'b0;
                    ref_addr = 0;
                end else ref_addr = ref_addr + 1;
            end
        end else if (start) begin
            ref_active = 1'b1;
            ref_addr = 0;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            check("R2 R7 valid", out_valid, ref_active);
            check("R3 addr", beat_addr, ref_addr);
            check("R7 last", out_last, ref_active && ref_addr == 127);
            if (ref_active) begin
                check("R5 R6 port A", bank_a_word, chan(ref_addr));
                check("R5 R6 port B", bank_b_word, chan(128 + ref_addr));
            end else begin
                check("R9 idle port A", bank_a_word, 0);
                check("R9 idle port B", bank_b_word, 0);
            end
            if (prev_stall) begin
                check("R4 hold A", bank_a_word, prev_a);
                check("R4 hold B", bank_b_word, prev_b);
            end
            prev_a = bank_a_word;
            prev_b = bank_b_word;
            prev_stall = out_valid && !in_ready;
        end
    end

    task automatic load_frame(int seed);
        for (int k = 0; k < CH; k++)
            latch_words[k*W +: W] = W'((k * 37 + seed * 113 + (k >> 3) * seed) ^ (seed << 4));
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        cycles++;
        in_ready = ($urandom_range(99) >= stall_pct);
    endtask

    task automatic run_frame(int seed, int pct, bit inject);
        load_frame(seed);
        stall_pct = pct;
        start = 1'b1;
        step();
        start = 1'b0;
        while (ref_active) begin
            // R8: inject start pulses mid-frame
            start = inject && ($urandom_range(9) == 0);
            step();
        end
        start = 1'b0;
        repeat (3) step();
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs during reset
        check("R1 valid", out_valid, 0);
        check("R1 last", out_last, 0);
        check("R1 addr", beat_addr, 0);
        check("R1 port A", bank_a_word, 0);
        check("R1 port B", bank_b_word, 0);
        rst_n = 1'b1;
        checking = 1'b1;
        step();
        repeat (2) step();
        run_frame(1, 0, 1'b0);
        run_frame(2, 40, 1'b0);
        run_frame(3, 30, 1'b1);
        run_frame(4, 0, 1'b1);
        run_frame(5, 70, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule